// File: doc/BRIEF.md
# Flag and CRC-16 Block Framer

This block sits between a single-wire token decoder/encoder pair and a command engine. Decoded bits arrive one at a time, least significant bit first, and are packed into bytes. Outside a block, each byte is read as an 8-bit flag. One flag value opens reception of a length-prefixed block, one requests the stored response and one asks the device to go to sleep. Every other value has no effect.

During a block, the first byte gives the total block length. Packet bytes are streamed to the command engine as they arrive. The two trailing bytes carry a CRC-16 that is checked against a checksum computed bit by bit over the length and packet bytes. The block ends with a done pulse and a good or bad indication. A bad block, or a length outside the legal range, replaces the stored response with a single failure byte, so the engine never has to act on it.

The command engine writes response packet bytes into a small buffer and commits a length. On each transmit flag, the framer wraps that packet as a full block and streams it, with valid/ready handshaking, to the token encoder. The full block is the length byte, the packet, then the CRC low byte and the CRC high byte. Input bits are assumed to arrive at most every other clock cycle, which is far faster than any pulse-timed wire allows.

Top module: `blk_framer`

## Requirements
- R1: Flag bytes are assembled least significant bit first. 0x66 starts block reception. 0xCC raises `sleep_req` for exactly one cycle and restores the wake response. Any flag value other than 0x66, 0x99 and 0xCC produces no packet, no done pulse, no sleep pulse and no change to the stored response.
- R2: On flag 0x99, the framer streams a block on `tx_data`. The block is the count (packet length + 3), then the packet bytes in buffer order, then the CRC low byte, then the CRC high byte.
- R3: The CRC-16 starts at 0x0000 and covers the count byte and the packet bytes. Each bit is taken in bus order, bit 0 of every byte first. For each bit, the feedback is that bit XOR CRC bit 15. The register shifts left by one, and when the feedback is 1 it is XORed with 0x8005.
- R4: The first block byte is the total block length, counting itself, the packet and the two CRC bytes. Bytes 1 to count−3 appear on `pkt_data` with `pkt_valid`, and `pkt_first` is set on byte 1 only.
- R5: The received CRC is low byte then high byte. On a match, `blk_done` pulses with `blk_ok`=1. On a mismatch, `blk_done` pulses with `blk_ok`=0 and the stored response becomes the single byte 0xFF.
- R6: A count byte below 4 or above 39 ends the block at once. `blk_done` pulses with `blk_ok`=0, no packet byte is emitted, the response becomes 0xFF, and the next byte is read as a flag.
- R7: After reset and after a sleep flag, the stored response is the single byte 0x11.
- R8: Repeated 0x99 flags each re-send the same stored response.
- R9: A response committed in the same cycle that a 0x99 flag completes is the one that is sent.
- R10: While `tx_valid` is high and `tx_ready` is low, `tx_data` and `tx_valid` hold.
- R11: Block counts of exactly 4 (one packet byte) and 39 (36 packet bytes) are accepted.
- R12: If an engine commit falls in the same cycle as a bad block's done pulse, the failure response 0xFF wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_bit_valid | input | 1 | A decoded bit is present |
| rx_bit | input | 1 | Decoded bit value |
| pkt_valid | output | 1 | Packet byte strobe to the command engine |
| pkt_data | output | 8 | Packet byte |
| pkt_first | output | 1 | Marks the first packet byte of a block |
| blk_done | output | 1 | Block finished (one cycle) |
| blk_ok | output | 1 | Block length and CRC were correct (valid with blk_done) |
| sleep_req | output | 1 | Sleep flag seen (one cycle) |
| rsp_wr_en | input | 1 | Write one response packet byte |
| rsp_wr_idx | input | 6 | Response byte position |
| rsp_wr_data | input | 8 | Response byte value |
| rsp_set_en | input | 1 | Commit the response length |
| rsp_set_len | input | 6 | Response packet length, 1 to 36 |
| tx_valid | output | 1 | Outgoing block byte present |
| tx_data | output | 8 | Outgoing block byte |
| tx_ready | input | 1 | Token encoder accepts the byte |

## Verification
Two cases are driven on purpose, because the engine's response commit can land in the same cycle as a framer event. In the first, the commit is driven in the cycle after the last bit of a 0x99 flag, which is the cycle the flag is decoded. The streamed block must then carry the new length and bytes, not the stale one-byte response. In the second, the commit arrives in the cycle a corrupted block completes, and the following transmit must return 0xFF. The scoreboard computes both expected streams, with their CRCs, from the requirement formulas.

// File: rtl/blkfrm_pkg.sv
package blkfrm_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned CRC_W  = 16;
    localparam logic [CRC_W-1:0] CRC_POLY = 16'h8005;

    localparam logic [BYTE_W-1:0] FLAG_CMD   = 8'h66;
    localparam logic [BYTE_W-1:0] FLAG_XMIT  = 8'h99;
    localparam logic [BYTE_W-1:0] FLAG_SLEEP = 8'hCC;
    localparam logic [BYTE_W-1:0] RSP_WAKE   = 8'h11;
    localparam logic [BYTE_W-1:0] RSP_FAIL   = 8'hFF;

    typedef enum logic [0:0] {FR_FLAG, FR_BLOCK} fr_state_e;
    typedef enum logic [1:0] {FLG_NONE, FLG_CMD, FLG_XMIT, FLG_SLEEP} flag_kind_e;

    typedef struct packed {
        logic              valid;
        logic [BYTE_W-1:0] data;
    } byte_s;

    function automatic flag_kind_e classify_flag(input logic [BYTE_W-1:0] b);
        flag_kind_e k;
        case (b)
            FLAG_CMD:   k = FLG_CMD;
            FLAG_XMIT:  k = FLG_XMIT;
            FLAG_SLEEP: k = FLG_SLEEP;
            default:    k = FLG_NONE;
        endcase
        return k;
    endfunction

    // One bus-order bit into the checksum register.
    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c, input logic b);
        logic fb;
        fb = b ^ c[CRC_W-1];
        return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    endfunction

    // A whole byte, bit 0 first, matching the wire order.
    function automatic logic [CRC_W-1:0] crc_byte(input logic [CRC_W-1:0] c, input logic [BYTE_W-1:0] d);
        logic [CRC_W-1:0] r;
        r = c;
        for (int i = 0; i < int'(BYTE_W); i++) r = crc_step(r, d[i]);
        return r;
    endfunction

endpackage

// File: rtl/bfr_bit_assembler.sv
module bfr_bit_assembler
    import blkfrm_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  align_clr,
    input  logic  bit_valid,
    input  logic  bit_in,
    output byte_s byte_o
);
    localparam int unsigned CNT_W = $clog2(BYTE_W);

    logic [BYTE_W-1:0] sreg_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [BYTE_W-1:0] shifted;

    assign shifted = {bit_in, sreg_q[BYTE_W-1:1]};

    always_ff @(posedge clk) begin
        if (rst || align_clr) begin
            sreg_q       <= '0;
            cnt_q        <= '0;
            byte_o.valid <= 1'b0;
            byte_o.data  <= '0;
        end else begin
            byte_o.valid <= 1'b0;
            if (bit_valid) begin
                sreg_q <= shifted;
                cnt_q  <= cnt_q + 1'b1;
                if (cnt_q == CNT_W'(BYTE_W - 1)) begin
                    byte_o.valid <= 1'b1;
                    byte_o.data  <= shifted;
                end
            end
        end
    end
endmodule

// File: rtl/bfr_crc16_serial.sv
module bfr_crc16_serial
    import blkfrm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             bit_en,
    input  logic             bit_in,
    output logic [CRC_W-1:0] crc_o
);
    always_ff @(posedge clk) begin
        if (rst || clr)   crc_o <= '0;
        else if (bit_en)  crc_o <= crc_step(crc_o, bit_in);
    end
endmodule

// File: rtl/bfr_rx_framer.sv
module bfr_rx_framer
    import blkfrm_pkg::*;
#(
    parameter int unsigned MIN_BLOCK = 4,
    parameter int unsigned MAX_BLOCK = 39
) (
    input  logic              clk,
    input  logic              rst,
    input  byte_s             rx_byte,
    input  logic [CRC_W-1:0]  crc_calc,
    output logic              crc_clr,
    output logic              crc_feed,
    output logic              pkt_valid,
    output logic [BYTE_W-1:0] pkt_data,
    output logic              pkt_first,
    output logic              blk_done,
    output logic              blk_ok,
    output logic              err_set,
    output logic              tx_start,
    output logic              sleep_req
);
    localparam logic [BYTE_W-1:0] CNT_MIN = BYTE_W'(MIN_BLOCK);
    localparam logic [BYTE_W-1:0] CNT_MAX = BYTE_W'(MAX_BLOCK);

    fr_state_e         st_q;
    logic [BYTE_W-1:0] idx_q, cnt_q, crc_lo_q;
    logic [BYTE_W-1:0] pkt_end;
    flag_kind_e        kind;
    logic              cnt_legal;

    assign kind      = classify_flag(rx_byte.data);
    assign pkt_end   = cnt_q - 8'd3;
    assign cnt_legal = (rx_byte.data >= CNT_MIN) && (rx_byte.data <= CNT_MAX);
    assign pkt_data  = rx_byte.data;

    // Checksum covers the count byte and the packet bytes only (R3).
    assign crc_feed = (st_q == FR_BLOCK) && ((idx_q == '0) || (idx_q <= pkt_end));

    always_comb begin
        crc_clr   = 1'b0;
        pkt_valid = 1'b0;
        pkt_first = 1'b0;
        blk_done  = 1'b0;
        blk_ok    = 1'b0;
        err_set   = 1'b0;
        tx_start  = 1'b0;
        sleep_req = 1'b0;
        if (rx_byte.valid) begin
            if (st_q == FR_FLAG) begin
                case (kind)
                    FLG_CMD:   crc_clr   = 1'b1;
                    FLG_XMIT:  tx_start  = 1'b1;
                    FLG_SLEEP: sleep_req = 1'b1;
                    default:   ;
                endcase
            end else if (idx_q == '0) begin
                if (!cnt_legal) begin           // R6 framing error
                    blk_done = 1'b1;
                    err_set  = 1'b1;
                end
            end else if (idx_q <= pkt_end) begin
                pkt_valid = 1'b1;               // R4
                pkt_first = (idx_q == 8'd1);
            end else if (idx_q == pkt_end + 8'd2) begin
                blk_done = 1'b1;                // R5
                blk_ok   = ({rx_byte.data, crc_lo_q} == crc_calc);
                err_set  = !blk_ok;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= FR_FLAG;
            idx_q    <= '0;
            cnt_q    <= '0;
            crc_lo_q <= '0;
        end else if (rx_byte.valid) begin
            if (st_q == FR_FLAG) begin
                if (kind == FLG_CMD) begin
                    st_q  <= FR_BLOCK;
                    idx_q <= '0;
                end
            end else begin
                idx_q <= idx_q + 8'd1;
                if (idx_q == '0) begin
                    cnt_q <= rx_byte.data;
                    if (!cnt_legal) st_q <= FR_FLAG;
                end else if (idx_q == pkt_end + 8'd1) begin
                    crc_lo_q <= rx_byte.data;
                end else if (idx_q == pkt_end + 8'd2) begin
                    st_q <= FR_FLAG;
                end
            end
        end
    end

    a_r6_done_returns_to_flag: assert property (@(posedge clk) disable iff (rst)
        blk_done |=> (st_q == FR_FLAG));
    a_r1_single_event: assert property (@(posedge clk) disable iff (rst)
        $onehot0({tx_start, sleep_req, blk_done, crc_clr, pkt_valid}));
endmodule

// File: rtl/bfr_rsp_buffer.sv
module bfr_rsp_buffer
    import blkfrm_pkg::*;
#(
    parameter int MAX_PKT = 36,
    parameter int LEN_W   = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sleep_set,
    input  logic              err_set,
    input  logic              eng_wr_en,
    input  logic [LEN_W-1:0]  eng_wr_idx,
    input  logic [BYTE_W-1:0] eng_wr_data,
    input  logic              eng_set_en,
    input  logic [LEN_W-1:0]  eng_set_len,
    input  logic [LEN_W-1:0]  rd_idx,
    output logic [BYTE_W-1:0] rd_data,
    output logic [LEN_W-1:0]  rsp_len
);
    logic [BYTE_W-1:0] mem [MAX_PKT];

    assign rd_data = (int'(rd_idx) < MAX_PKT) ? mem[rd_idx] : '0;

    // Priority: reset/sleep, then failure (R12), then engine writes.
    always_ff @(posedge clk) begin
        if (rst || sleep_set) begin
            mem[0]  <= RSP_WAKE;
            rsp_len <= LEN_W'(1);
        end else if (err_set) begin
            mem[0]  <= RSP_FAIL;
            rsp_len <= LEN_W'(1);
        end else begin
            if (eng_wr_en && int'(eng_wr_idx) < MAX_PKT) mem[eng_wr_idx] <= eng_wr_data;
            if (eng_set_en) rsp_len <= eng_set_len;
        end
    end

    a_r5_fail_response: assert property (@(posedge clk) disable iff (rst)
        (err_set && !sleep_set) |=> (rsp_len == LEN_W'(1) && mem[0] == RSP_FAIL));
    a_r7_sleep_response: assert property (@(posedge clk) disable iff (rst)
        sleep_set |=> (rsp_len == LEN_W'(1) && mem[0] == RSP_WAKE));
endmodule

// File: rtl/bfr_tx_stream.sv
module bfr_tx_stream
    import blkfrm_pkg::*;
#(
    parameter int MAX_BLOCK = 39,
    parameter int LEN_W     = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [LEN_W-1:0]  rsp_len,
    output logic [LEN_W-1:0]  rd_idx,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data,
    input  logic              tx_ready
);
    logic              busy_q;
    logic [BYTE_W-1:0] pos_q;
    logic [CRC_W-1:0]  crc_q;
    logic [BYTE_W-1:0] len8;
    logic              fire;

    assign len8     = BYTE_W'(rsp_len);
    assign rd_idx   = LEN_W'(pos_q - 8'd1);
    assign tx_valid = busy_q;
    assign fire     = busy_q && tx_ready;

    always_comb begin
        if (pos_q == '0)                tx_data = len8 + 8'd3;
        else if (pos_q <= len8)         tx_data = rd_data;
        else if (pos_q == len8 + 8'd1)  tx_data = crc_q[7:0];
        else                            tx_data = crc_q[15:8];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            pos_q  <= '0;
            crc_q  <= '0;
        end else if (!busy_q) begin
            if (start) begin
                busy_q <= 1'b1;
                pos_q  <= '0;
                crc_q  <= '0;
            end
        end else if (fire) begin
            if (pos_q <= len8) crc_q <= crc_byte(crc_q, tx_data);
            if (pos_q == len8 + 8'd2) busy_q <= 1'b0;
            else                      pos_q  <= pos_q + 8'd1;
        end
    end

    a_r10_hold_when_stalled: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));
    a_r2_count_in_range: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_valid) |-> (tx_data >= 8'd4 && tx_data <= BYTE_W'(MAX_BLOCK)));
endmodule

// File: rtl/blk_framer.sv
module blk_framer
    import blkfrm_pkg::*;
#(
    parameter int MIN_BLOCK = 4,
    parameter int MAX_BLOCK = 39,
    localparam int MAX_PKT  = MAX_BLOCK - 3,
    localparam int LEN_W    = $clog2(MAX_PKT + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_bit_valid,
    input  logic              rx_bit,
    output logic              pkt_valid,
    output logic [BYTE_W-1:0] pkt_data,
    output logic              pkt_first,
    output logic              blk_done,
    output logic              blk_ok,
    output logic              sleep_req,
    input  logic              rsp_wr_en,
    input  logic [LEN_W-1:0]  rsp_wr_idx,
    input  logic [BYTE_W-1:0] rsp_wr_data,
    input  logic              rsp_set_en,
    input  logic [LEN_W-1:0]  rsp_set_len,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data,
    input  logic              tx_ready
);
    byte_s             rx_byte;
    logic [CRC_W-1:0]  crc_calc;
    logic              crc_clr, crc_feed, err_set, tx_start;
    logic [LEN_W-1:0]  rd_idx, rsp_len;
    logic [BYTE_W-1:0] rd_data;

    bfr_bit_assembler u_asm (
        .clk(clk), .rst(rst), .align_clr(sleep_req),
        .bit_valid(rx_bit_valid), .bit_in(rx_bit), .byte_o(rx_byte)
    );

    bfr_crc16_serial u_crc (
        .clk(clk), .rst(rst), .clr(crc_clr),
        .bit_en(rx_bit_valid && crc_feed), .bit_in(rx_bit), .crc_o(crc_calc)
    );

    bfr_rx_framer #(.MIN_BLOCK(MIN_BLOCK), .MAX_BLOCK(MAX_BLOCK)) u_rx (
        .clk(clk), .rst(rst), .rx_byte(rx_byte), .crc_calc(crc_calc),
        .crc_clr(crc_clr), .crc_feed(crc_feed),
        .pkt_valid(pkt_valid), .pkt_data(pkt_data), .pkt_first(pkt_first),
        .blk_done(blk_done), .blk_ok(blk_ok), .err_set(err_set),
        .tx_start(tx_start), .sleep_req(sleep_req)
    );

    bfr_rsp_buffer #(.MAX_PKT(MAX_PKT), .LEN_W(LEN_W)) u_buf (
        .clk(clk), .rst(rst), .sleep_set(sleep_req), .err_set(err_set),
        .eng_wr_en(rsp_wr_en), .eng_wr_idx(rsp_wr_idx), .eng_wr_data(rsp_wr_data),
        .eng_set_en(rsp_set_en), .eng_set_len(rsp_set_len),
        .rd_idx(rd_idx), .rd_data(rd_data), .rsp_len(rsp_len)
    );

    // The streamer reads the length live, so a commit landing on the
    // flag's decode edge is already visible to the first byte (R9).
    bfr_tx_stream #(.MAX_BLOCK(MAX_BLOCK), .LEN_W(LEN_W)) u_tx (
        .clk(clk), .rst(rst), .start(tx_start), .rsp_len(rsp_len),
        .rd_idx(rd_idx), .rd_data(rd_data),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready)
    );
endmodule

// File: tb/blk_framer_tb.sv
`timescale 1ns/1ps
module blk_framer_tb;
    localparam int LW = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_bit_valid = 1'b0, rx_bit = 1'b0;
    logic pkt_valid, pkt_first, blk_done, blk_ok, sleep_req, tx_valid;
    logic [7:0] pkt_data, tx_data;
    logic rsp_wr_en = 1'b0, rsp_set_en = 1'b0, tx_ready = 1'b1;
    logic [LW-1:0] rsp_wr_idx = '0, rsp_set_len = '0;
    logic [7:0] rsp_wr_data = '0;

    always #2.5 clk = ~clk;

    blk_framer u_dut (
        .clk(clk), .rst(rst), .rx_bit_valid(rx_bit_valid), .rx_bit(rx_bit),
        .pkt_valid(pkt_valid), .pkt_data(pkt_data), .pkt_first(pkt_first),
        .blk_done(blk_done), .blk_ok(blk_ok), .sleep_req(sleep_req),
        .rsp_wr_en(rsp_wr_en), .rsp_wr_idx(rsp_wr_idx), .rsp_wr_data(rsp_wr_data),
        .rsp_set_en(rsp_set_en), .rsp_set_len(rsp_set_len),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready)
    );

    typedef struct { logic [7:0] v; logic first; string tag; } exp_t;
    typedef logic [7:0] bytes_t [$];

    exp_t  q_tx[$];
    exp_t  q_pkt[$];
    exp_t  q_done[$];
    int    checks = 0, errors = 0, sleep_seen = 0, cyc = 0;
    bit    bp_mode = 1'b0;
    bit    finished = 1'b0;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r = c;
        for (int i = 0; i < 8; i++) begin
            logic fb = d[i] ^ r[15];
            r = {r[14:0], 1'b0};
            if (fb) r = r ^ 16'h8005;
        end
        return r;
    endfunction

    // Scoreboard monitor: pops expected items as the design produces them.
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (!rst) begin
                cyc++;
                tx_ready = bp_mode ? ((cyc % 3) != 0) : 1'b1;
                if (tx_valid && tx_ready) begin
                    if (q_tx.size() == 0) check(0, "R2", "unexpected tx byte", tx_data, 0);
                    else begin
                        e = q_tx.pop_front();
                        check(tx_data == e.v, e.tag, "tx byte", tx_data, e.v);
                    end
                end
                if (pkt_valid) begin
                    if (q_pkt.size() == 0) check(0, "R1", "unexpected packet byte", pkt_data, 0);
                    else begin
                        e = q_pkt.pop_front();
                        check(pkt_data == e.v, e.tag, "packet byte", pkt_data, e.v);
                        check(pkt_first == e.first, e.tag, "pkt_first", pkt_first, e.first);
                    end
                end
                if (blk_done) begin
                    if (q_done.size() == 0) check(0, "R1", "unexpected done", blk_ok, 0);
                    else begin
                        e = q_done.pop_front();
                        check(blk_ok == e.v[0], e.tag, "blk_ok", blk_ok, e.v[0]);
                    end
                end
                if (sleep_req) sleep_seen++;
            end
        end
    end

    task automatic send_bit(input logic b);
        @(negedge clk);
        @(negedge clk); rx_bit_valid = 1'b1; rx_bit = b;
        @(negedge clk); rx_bit_valid = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 0; i < 8; i++) send_bit(b[i]);
    endtask

    task automatic pulse_set(input int len);
        rsp_set_en = 1'b1; rsp_set_len = LW'(len);
        @(negedge clk); rsp_set_en = 1'b0;
    endtask

    task automatic expect_rsp(input bytes_t pkt, input string tag);
        logic [15:0] c = 16'h0;
        logic [7:0]  cnt = 8'(pkt.size() + 3);
        c = crc_upd(c, cnt);
        q_tx.push_back('{cnt, 1'b0, tag});
        foreach (pkt[i]) begin
            c = crc_upd(c, pkt[i]);
            q_tx.push_back('{pkt[i], 1'b0, tag});
        end
        q_tx.push_back('{c[7:0], 1'b0, tag});
        q_tx.push_back('{c[15:8], 1'b0, tag});
    endtask

    task automatic send_block(input bytes_t pkt, input bit corrupt, input string tag,
                              input int collide_len);
        logic [15:0] c = 16'h0;
        logic [7:0]  cnt = 8'(pkt.size() + 3);
        c = crc_upd(c, cnt);
        foreach (pkt[i]) begin
            c = crc_upd(c, pkt[i]);
            q_pkt.push_back('{pkt[i], (i == 0), tag});
        end
        q_done.push_back('{{7'b0, !corrupt}, 1'b0, tag});
        send_byte(8'h66);
        send_byte(cnt);
        foreach (pkt[i]) send_byte(pkt[i]);
        send_byte(c[7:0] ^ {7'b0, corrupt});
        send_byte(c[15:8]);
        if (collide_len != 0) pulse_set(collide_len);
    endtask

    task automatic load_rsp(input bytes_t pkt, input bit commit);
        foreach (pkt[i]) begin
            @(negedge clk);
            rsp_wr_en = 1'b1; rsp_wr_idx = LW'(i); rsp_wr_data = pkt[i];
            @(negedge clk); rsp_wr_en = 1'b0;
        end
        if (commit) begin @(negedge clk); pulse_set(pkt.size()); end
    endtask

    task automatic drain(input string tag);
        int n = 0;
        while ((q_tx.size() != 0 || q_pkt.size() != 0 || q_done.size() != 0) && n < 3000) begin
            @(negedge clk); n++;
        end
        repeat (3) @(negedge clk);
        check(q_tx.size() == 0 && q_pkt.size() == 0 && q_done.size() == 0, tag,
              "pending expected items", q_tx.size() + q_pkt.size() + q_done.size(), 0);
        check(tx_valid == 1'b0, tag, "tx idle after block", tx_valid, 0);
    endtask

    initial begin
        bytes_t big;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R7 reset state
        check(!tx_valid && !pkt_valid && !blk_done && !sleep_req, "R7", "outputs idle after reset",
              {tx_valid, pkt_valid, blk_done, sleep_req}, 0);
        expect_rsp('{8'h11}, "R7");
        send_byte(8'h99);
        drain("R7");

        // R1: unknown flag has no effect; R8 re-read
        send_byte(8'h5A);
        expect_rsp('{8'h11}, "R8");
        send_byte(8'h99);
        drain("R1");
        check(sleep_seen == 0, "R1", "no sleep on unknown flag", sleep_seen, 0);

        // R3/R4/R5 good block
        send_block('{8'h08, 8'h01, 8'h02, 8'h00, 8'hAA, 8'h55}, 1'b0, "R4", 0);
        drain("R3");

        // R2/R10 engine response under backpressure, R8 repeat
        load_rsp('{8'h00, 8'h7E, 8'hC3}, 1'b1);
        bp_mode = 1'b1;
        expect_rsp('{8'h00, 8'h7E, 8'hC3}, "R10");
        send_byte(8'h99);
        drain("R10");
        expect_rsp('{8'h00, 8'h7E, 8'hC3}, "R8");
        send_byte(8'h99);
        drain("R8");
        bp_mode = 1'b0;

        // R5 CRC mismatch
        send_block('{8'h40, 8'h20, 8'h00, 8'h00}, 1'b1, "R5", 0);
        expect_rsp('{8'hFF}, "R5");
        send_byte(8'h99);
        drain("R5");

        // R6 count too small, then too large
        load_rsp('{8'h00}, 1'b1);
        q_done.push_back('{8'h00, 1'b0, "R6"});
        send_byte(8'h66); send_byte(8'h03);
        expect_rsp('{8'hFF}, "R6");
        send_byte(8'h99);
        drain("R6");
        load_rsp('{8'h00}, 1'b1);
        q_done.push_back('{8'h00, 1'b0, "R6"});
        send_byte(8'h66); send_byte(8'd40);
        expect_rsp('{8'hFF}, "R6");
        send_byte(8'h99);
        drain("R6");

        // R11 boundary counts 4 and 39
        send_block('{8'h5C}, 1'b0, "R11", 0);
        drain("R11");
        for (int i = 0; i < 36; i++) big.push_back(8'(i * 7 + 3));
        send_block(big, 1'b0, "R11", 0);
        drain("R11");

        // R9 commit in the flag's decode cycle
        load_rsp('{8'hDE, 8'hAD, 8'hBE}, 1'b0);
        expect_rsp('{8'hDE, 8'hAD, 8'hBE}, "R9");
        send_byte(8'h99);
        pulse_set(3);
        drain("R9");

        // R12 commit in the bad block's done cycle
        load_rsp('{8'h01, 8'h02}, 1'b0);
        send_block('{8'h11, 8'h22}, 1'b1, "R12", 2);
        expect_rsp('{8'hFF}, "R12");
        send_byte(8'h99);
        drain("R12");

        // R1/R7 sleep flag
        load_rsp('{8'h00}, 1'b1);
        send_byte(8'hCC);
        repeat (3) @(negedge clk);
        check(sleep_seen == 1, "R1", "sleep pulse count", sleep_seen, 1);
        expect_rsp('{8'h11}, "R7");
        send_byte(8'h99);
        drain("R7");

        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule